// File: doc/BRIEF.md
# Timer Channel Host Port

This block is the byte-wide register front end of a three-channel interval timer. A host reaches it through a two-bit address, a write strobe, a read strobe and an eight-bit data bus. Addresses 0 to 2 are the data ports of the three channels. Address 3 is a control port, and it only accepts writes. For each channel the block holds a 16-bit reload value, an operating-mode code and an access mode. A one-cycle load strobe tells the counting core that a new reload value is complete.

Each channel has a small write sequencer. It steers incoming bytes into the low or the high half of the reload value, as the access mode directs. A count-latch command freezes a snapshot of the live count, which the counting core drives into the block. The snapshot is kept until the host has read both of its bytes. Reads alternate between the low byte and the high byte. A channel in rate-generator mode that is already running is not restarted when it is reloaded. The counting core picks up the new value at its next natural reload.

Top module: `tmr_host_port`

## Requirements
- R1: Address values 0, 1 and 2 select the data ports of channels 0, 1 and 2. Address 3 is the control port, and a read there returns 0x00.
- R2: A control byte carries the channel in bits 7:6, the access mode in bits 5:4 and the operating mode in bits 3:1. Bit 0 is unused. With access mode 1, 2 or 3 the channel stores both fields, and its `op_mode` slice shows the new operating mode on the cycle after the write.
- R3: Access mode 3 (low then high) takes the first data byte into reload bits 7:0 and the second into bits 15:8. The sequencer then expects a low byte again.
- R4: Access mode 1 makes every data write replace reload bits 7:0 only. Access mode 2 makes every data write replace bits 15:8 only.
- R5: When a reload value becomes complete, the channel's `load_pend` bit is high for exactly the one cycle after that write. A value is complete after the high byte in mode 3, or after any byte in modes 1 and 2. It is not complete after the low byte in mode 3.
- R6: If the channel's operating mode has its low two bits equal to 2'b10 (rate generator) and its `cnt_running` input is high, a completed reload updates `reload_val` but raises no `load_pend`.
- R7: A control byte with access mode 0 (latch) copies the live count into a snapshot only when no snapshot is held. It leaves the operating mode and the access mode unchanged. A latch command issued while a snapshot is held is ignored.
- R8: Data-port reads return the low byte first and the high byte next, and keep alternating. They are taken from the snapshot while one is held, and from the live count otherwise.
- R9: Reading the high byte of a held snapshot releases it, so later reads return the live count.
- R10: Any control byte addressed to a channel puts that channel's read toggle back on the low byte.
- R11: A control byte whose channel field is 3 changes no channel state.
- R12: After reset every reload value and operating mode is 0, no `load_pend` is high, no snapshot is held and reads start on the low byte. Data writes made before a channel's first mode-setting control byte are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Port select: 0 to 2 data ports, 3 control |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data, combinational from address and state |
| cnt_live | input | 48 | Live count of each channel, 16 bits per channel, channel 0 in bits 15:0 |
| cnt_running | input | 3 | Per channel: the counting core is running |
| reload_val | output | 48 | Reload value of each channel, 16 bits per channel |
| op_mode | output | 9 | Operating mode of each channel, 3 bits per channel |
| load_pend | output | 3 | Per channel: one-cycle strobe for a new complete reload value |

## Verification
The byte sequencer is tried with three patterns:
- low-then-high pairs, which separate the two halves and show the return to the low byte;
- repeated single-byte writes in low-only and high-only mode, which show that the other half is kept;
- data writes before any mode is set, which must change nothing.

Latch handling is tried in three ways:
- a second latch while a snapshot is held, against a changed live count, which tells apart a held snapshot from a recaptured one;
- a read past the high byte, which shows the release;
- a control write made in the middle of a read pair, which shows the toggle reset.

Reload while running is tried in rate-generator mode, in its aliased code, and in a non-rate mode. This tells apart the suppression from an unconditional restart.

// File: rtl/tmr_host_pkg.sv
package tmr_host_pkg;

   // write sequencer: which byte the next data write fills
   typedef enum logic [1:0] {
      WS_IDLE = 2'd0,
      WS_LO   = 2'd1,
      WS_HI   = 2'd2
   } wseq_e;

   // access-mode field values of a control byte
   localparam logic [1:0] AM_LATCH = 2'd0;
   localparam logic [1:0] AM_LO    = 2'd1;
   localparam logic [1:0] AM_HI    = 2'd2;
   localparam logic [1:0] AM_BOTH  = 2'd3;

   // low bits of the operating mode that mark a rate generator
   localparam logic [1:0] RATE_LOW_BITS = 2'b10;

endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec #(
   parameter int NUM_CH = 3,
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8,
   parameter int OP_W   = 3
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [NUM_CH-1:0] data_wr_o,
   output logic [NUM_CH-1:0] data_rd_o,
   output logic [NUM_CH-1:0] ctrl_wr_o,
   output logic [1:0]        ctrl_am_o,
   output logic [OP_W-1:0]   ctrl_op_o
);
   localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'((1 << ADDR_W) - 1);
   localparam int CH_LSB = DATA_W - ADDR_W;
   localparam int AM_LSB = OP_W + 1;

   logic              ctrl_hit;
   logic [ADDR_W-1:0] ctrl_ch;
   logic              unused_wbits;

   assign ctrl_hit  = wr_i && (addr_i == CTRL_ADDR);
   assign ctrl_ch   = wdata_i[CH_LSB +: ADDR_W];
   assign ctrl_am_o = wdata_i[AM_LSB +: 2];
   assign ctrl_op_o = wdata_i[1 +: OP_W];
   assign unused_wbits = ^wdata_i;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
      assign data_wr_o[i] = wr_i && (addr_i == ADDR_W'(i));
      assign data_rd_o[i] = rd_i && (addr_i == ADDR_W'(i));
      assign ctrl_wr_o[i] = ctrl_hit && (ctrl_ch == ADDR_W'(i));
   end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
   import tmr_host_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16,
   parameter int OP_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_sel_i,
   input  logic              rd_sel_i,
   input  logic              ctrl_sel_i,
   input  logic [1:0]        ctrl_am_i,
   input  logic [OP_W-1:0]   ctrl_op_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [CNT_W-1:0]  live_i,
   input  logic              run_i,
   output logic [CNT_W-1:0]  reload_o,
   output logic [OP_W-1:0]   op_o,
   output logic              pend_o,
   output logic [DATA_W-1:0] rdata_o
);
   logic [1:0]       amode_q;
   logic [OP_W-1:0]  op_q;
   wseq_e            wst_q;
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] snap_q;
   logic             latched_q;
   logic             tog_q;
   logic             pend_q;

   logic             byte_done;
   logic             keep_run;
   logic [CNT_W-1:0] rd_src;

   // a reload value is complete after the high byte, or after any byte in single-byte modes
   assign byte_done = wr_sel_i &&
                      (wst_q == WS_HI || (wst_q == WS_LO && amode_q != AM_BOTH));
   assign keep_run  = (op_q[1:0] == RATE_LOW_BITS) && run_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         amode_q   <= AM_LATCH;
         op_q      <= '0;
         wst_q     <= WS_IDLE;
         reload_q  <= '0;
         snap_q    <= '0;
         latched_q <= 1'b0;
         tog_q     <= 1'b0;
         pend_q    <= 1'b0;
      end else begin
         pend_q <= byte_done && !keep_run;
         if (ctrl_sel_i) begin
            tog_q <= 1'b0;
            if (ctrl_am_i == AM_LATCH) begin
               if (!latched_q) begin
                  snap_q    <= live_i;
                  latched_q <= 1'b1;
               end
            end else begin
               amode_q <= ctrl_am_i;
               op_q    <= ctrl_op_i;
               wst_q   <= (ctrl_am_i == AM_HI) ? WS_HI : WS_LO;
            end
         end else begin
            if (wr_sel_i) begin
               case (wst_q)
                  WS_LO: begin
                     reload_q[DATA_W-1:0] <= wdata_i;
                     if (amode_q == AM_BOTH) wst_q <= WS_HI;
                  end
                  WS_HI: begin
                     reload_q[CNT_W-1:DATA_W] <= wdata_i;
                     if (amode_q == AM_BOTH) wst_q <= WS_LO;
                  end
                  default: ;
               endcase
            end
            if (rd_sel_i) begin
               tog_q <= !tog_q;
               if (tog_q && latched_q) latched_q <= 1'b0;
            end
         end
      end
   end

   assign rd_src   = latched_q ? snap_q : live_i;
   assign rdata_o  = tog_q ? rd_src[CNT_W-1:DATA_W] : rd_src[DATA_W-1:0];
   assign reload_o = reload_q;
   assign op_o     = op_q;
   assign pend_o   = pend_q;

   AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (latched_q && !(rd_sel_i && tog_q)) |=> (latched_q && $stable(snap_q))); // R7
   AST_SNAP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel_i && tog_q && latched_q && !ctrl_sel_i) |=> !latched_q); // R9
   AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel_i && !ctrl_sel_i && wst_q == WS_HI) |=> $stable(reload_q[DATA_W-1:0])); // R4
   AST_RATE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel_i && wst_q == WS_HI && op_q[1:0] == RATE_LOW_BITS && run_i) |=> !pend_o); // R6
   AST_CTRL_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_sel_i |=> !tog_q); // R10
   AST_PEND_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      pend_o |-> $past(wr_sel_i)); // R5
endmodule

// File: rtl/tmr_host_port.sv
module tmr_host_port #(
   parameter int NUM_CH = 3,
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16,
   parameter int OP_W   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic                     bus_wr,
   input  logic                     bus_rd,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   input  logic [NUM_CH*CNT_W-1:0]  cnt_live,
   input  logic [NUM_CH-1:0]        cnt_running,
   output logic [NUM_CH*CNT_W-1:0]  reload_val,
   output logic [NUM_CH*OP_W-1:0]   op_mode,
   output logic [NUM_CH-1:0]        load_pend
);
   localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'((1 << ADDR_W) - 1);
   localparam int CTRL_BITS = ADDR_W + 2 + OP_W + 1;

   if (CNT_W != 2 * DATA_W) begin : g_bad_cnt
      $error("CNT_W must be twice DATA_W");
   end
   if (NUM_CH > (1 << ADDR_W) - 1) begin : g_bad_ch
      $error("NUM_CH leaves no address for the control port");
   end
   if (CTRL_BITS > DATA_W) begin : g_bad_ctrl
      $error("control byte fields do not fit DATA_W");
   end

   logic [NUM_CH-1:0] data_wr;
   logic [NUM_CH-1:0] data_rd;
   logic [NUM_CH-1:0] ctrl_wr;
   logic [1:0]        ctrl_am;
   logic [OP_W-1:0]   ctrl_op;
   logic [DATA_W-1:0] ch_rdata [NUM_CH];

   tmr_addr_dec #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .OP_W   (OP_W)
   ) dec_i (
      .addr_i    (bus_addr),
      .wr_i      (bus_wr),
      .rd_i      (bus_rd),
      .wdata_i   (bus_wdata),
      .data_wr_o (data_wr),
      .data_rd_o (data_rd),
      .ctrl_wr_o (ctrl_wr),
      .ctrl_am_o (ctrl_am),
      .ctrl_op_o (ctrl_op)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      tmr_chan_regs #(
         .DATA_W (DATA_W),
         .CNT_W  (CNT_W),
         .OP_W   (OP_W)
      ) chan_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_sel_i   (data_wr[i]),
         .rd_sel_i   (data_rd[i]),
         .ctrl_sel_i (ctrl_wr[i]),
         .ctrl_am_i  (ctrl_am),
         .ctrl_op_i  (ctrl_op),
         .wdata_i    (bus_wdata),
         .live_i     (cnt_live[i*CNT_W +: CNT_W]),
         .run_i      (cnt_running[i]),
         .reload_o   (reload_val[i*CNT_W +: CNT_W]),
         .op_o       (op_mode[i*OP_W +: OP_W]),
         .pend_o     (load_pend[i]),
         .rdata_o    (ch_rdata[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (bus_addr == ADDR_W'(i)) bus_rdata = ch_rdata[i];
      end
   end

   AST_CTRL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == CTRL_ADDR) |-> (bus_rdata == '0)); // R1
   AST_CTRL_NOT_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == CTRL_ADDR) |=> (load_pend == '0)); // R5
endmodule

// File: tb/tmr_host_port_tb_top.sv
`timescale 1ns/1ps
module tmr_host_port_tb_top;
   localparam int NV = 29;
   // {req[3:0], op[1:0], addr[1:0], data[7:0], exp[15:0]}; op 0 write, 1 read, 2 reload, 3 pend mask
   localparam logic [31:0] VEC [NV] = '{
      {4'd2,  2'd0, 2'd3, 8'h34, 16'h0000},  // R2 ch0 mode3 op2
      {4'd3,  2'd0, 2'd0, 8'h34, 16'h0000},  // R3 low byte
      {4'd5,  2'd3, 2'd0, 8'h00, 16'h0000},  // R5 no strobe after low half
      {4'd3,  2'd0, 2'd0, 8'h12, 16'h0000},  // R3 high byte
      {4'd5,  2'd3, 2'd0, 8'h00, 16'h0001},  // R5 strobe ch0
      {4'd3,  2'd2, 2'd0, 8'h00, 16'h1234},  // R3
      {4'd3,  2'd0, 2'd0, 8'h78, 16'h0000},  // R3 back to low
      {4'd3,  2'd0, 2'd0, 8'h56, 16'h0000},  // R3
      {4'd5,  2'd3, 2'd0, 8'h00, 16'h0001},  // R5
      {4'd3,  2'd2, 2'd0, 8'h00, 16'h5678},  // R3
      {4'd8,  2'd1, 2'd0, 8'h00, 16'h00B2},  // R8 live low
      {4'd8,  2'd1, 2'd0, 8'h00, 16'h00A1},  // R8 live high
      {4'd2,  2'd0, 2'd3, 8'h50, 16'h0000},  // R2 ch1 mode1
      {4'd4,  2'd0, 2'd1, 8'h99, 16'h0000},  // R4
      {4'd5,  2'd3, 2'd0, 8'h00, 16'h0002},  // R5 strobe ch1
      {4'd4,  2'd2, 2'd1, 8'h00, 16'h0099},  // R4
      {4'd4,  2'd0, 2'd1, 8'h11, 16'h0000},  // R4
      {4'd5,  2'd3, 2'd0, 8'h00, 16'h0002},  // R5
      {4'd4,  2'd2, 2'd1, 8'h00, 16'h0011},  // R4
      {4'd2,  2'd0, 2'd3, 8'hA0, 16'h0000},  // R2 ch2 mode2
      {4'd4,  2'd0, 2'd2, 8'h77, 16'h0000},  // R4
      {4'd5,  2'd3, 2'd0, 8'h00, 16'h0004},  // R5 strobe ch2
      {4'd4,  2'd2, 2'd2, 8'h00, 16'h7700},  // R4
      {4'd1,  2'd1, 2'd3, 8'h00, 16'h0000},  // R1 control reads zero
      {4'd11, 2'd0, 2'd3, 8'hD0, 16'h0000},  // R11 channel field 3
      {4'd11, 2'd0, 2'd1, 8'h22, 16'h0000},  // R11 ch1 still mode1
      {4'd11, 2'd3, 2'd0, 8'h00, 16'h0002},  // R11
      {4'd11, 2'd2, 2'd1, 8'h00, 16'h0022},  // R11
      {4'd11, 2'd2, 2'd0, 8'h00, 16'h5678}   // R11 ch0 untouched
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [15:0] live0 = 16'hA1B2;
   logic [15:0] live1 = 16'h1357;
   logic [15:0] live2 = 16'hCAFE;
   logic [47:0] cnt_live;
   logic [2:0]  cnt_running = '0;
   logic [47:0] reload_val;
   logic [8:0]  op_mode;
   logic [2:0]  load_pend;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   assign cnt_live = {live2, live1, live0};

   always #2.5 clk = ~clk;

   tmr_host_port dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr    (bus_addr),
      .bus_wr      (bus_wr),
      .bus_rd      (bus_rd),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .cnt_live    (cnt_live),
      .cnt_running (cnt_running),
      .reload_val  (reload_val),
      .op_mode     (op_mode),
      .load_pend   (load_pend)
   );

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      bus_addr = a;
      bus_wdata = d;
      bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
      bus_addr = a;
      bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(posedge clk);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] rv;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12 reset state
      check("R12 reload", reload_val[31:0], 32'h0);
      check("R12 reload ch2", reload_val[47:32], 16'h0);
      check("R12 op_mode", {7'd0, op_mode}, 16'h0);
      check("R12 load_pend", {13'd0, load_pend}, 16'h0);
      bus_read(2'd0, rv);
      check("R12 first read low", {8'd0, rv}, 16'h00B2);
      bus_read(2'd0, rv);
      check("R12 second read high", {8'd0, rv}, 16'h00A1);
      bus_write(2'd0, 8'h55);
      check("R12 write before mode pend", {13'd0, load_pend}, 16'h0);
      check("R12 write before mode reload", reload_val[15:0], 16'h0);

      // vector walk
      for (int i = 0; i < NV; i++) begin
         automatic logic [3:0]  vr = VEC[i][31:28];
         automatic logic [1:0]  vo = VEC[i][27:26];
         automatic logic [1:0]  va = VEC[i][25:24];
         automatic logic [7:0]  vd = VEC[i][23:16];
         automatic logic [15:0] ve = VEC[i][15:0];
         automatic string tag = $sformatf("R%0d vec%0d", vr, i);
         case (vo)
            2'd0: bus_write(va, vd);
            2'd1: begin bus_read(va, rv); check(tag, {8'd0, rv}, ve); end
            2'd2: check(tag, reload_val[va*16 +: 16], ve);
            default: check(tag, {13'd0, load_pend}, ve);
         endcase
      end

      // R2 op code stored; R7 latch keeps modes
      bus_write(2'd3, 8'hAE);
      check("R2 ch2 op 7", {13'd0, op_mode[8:6]}, 16'd7);
      live0 = 16'h1234;
      bus_write(2'd3, 8'h00);
      check("R7 latch keeps op", {13'd0, op_mode[2:0]}, 16'd2);
      live0 = 16'h9999;
      bus_write(2'd3, 8'h00);
      bus_read(2'd0, rv);
      check("R7 snapshot low", {8'd0, rv}, 16'h0034);
      bus_read(2'd0, rv);
      check("R8 snapshot high", {8'd0, rv}, 16'h0012);
      bus_read(2'd0, rv);
      check("R9 live after release", {8'd0, rv}, 16'h0099);
      bus_read(2'd0, rv);

      // R6 rate generator running
      cnt_running = 3'b001;
      bus_write(2'd0, 8'h01);
      bus_write(2'd0, 8'h02);
      check("R6 no strobe", {13'd0, load_pend}, 16'h0);
      check("R6 reload updated", reload_val[15:0], 16'h0201);
      bus_write(2'd3, 8'h3C);
      bus_write(2'd0, 8'h05);
      bus_write(2'd0, 8'h06);
      check("R6 alias op6 no strobe", {13'd0, load_pend}, 16'h0);
      bus_write(2'd3, 8'h30);
      bus_write(2'd0, 8'h03);
      bus_write(2'd0, 8'h04);
      check("R6 non-rate strobes", {13'd0, load_pend}, 16'h0001);
      check("R6 reload", reload_val[15:0], 16'h0403);
      cnt_running = 3'b000;

      // R10 control write resets read toggle
      live0 = 16'h5AC3;
      bus_read(2'd0, rv);
      check("R10 first low", {8'd0, rv}, 16'h00C3);
      bus_write(2'd3, 8'h34);
      bus_read(2'd0, rv);
      check("R10 low after control", {8'd0, rv}, 16'h00C3);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule